// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers five event sources into sticky status bits and combines them into a single interrupt request line. Each status bit has an enable bit in a mask register, and a 1 there lets the bit through. The request line is high whenever any enabled status bit is set. Four of the sources arrive as single-cycle event pulses. These are hot-plug rise, hot-plug fall, nonce refresh and random-number error. The fifth source is a level from an attached core. Only a low-to-high transition of that level is latched. A small edge-tracking state machine with the states LVL_LOW and LVL_HIGH finds the transition. The machine moves from LVL_LOW to LVL_HIGH when the level is seen high, and this is the only transition that reports a rise. It moves from LVL_HIGH back to LVL_LOW when the level is seen low. Reset places it in LVL_LOW.

Software reaches the block through a plain port made of an address, a write enable and write data, with combinational read data. There are three registers. Address 0 is the mask. Address 1 is the status: writing 1s forces bits on, and bit 31 of the read value shows the live core level. Address 2 is a clear register: writing 1s clears the matching status bits, and it reads as zero. If a hardware event and a software clear reach the same bit in one cycle, the event wins.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: After reset the mask and all status bits are 0, irq_out is 0, and the edge tracker is in LVL_LOW.
- R2: A write to address 0 stores reg_wdata[4:0] as the mask. Reading address 0 returns the mask in bits 4:0 with every other bit 0. Reading any address other than 0 or 1 returns 0.
- R3: An event pulse on hpd_rise_evt, hpd_fall_evt, nonce_evt or rnd_err_evt sets status bit 1, 2, 3 or 4 respectively at the next clock edge. The bit then stays set until it is cleared.
- R4: Status bit 0 is set at the clock edge after core_irq_lvl is first seen high following a low, or following reset. A level that stays high does not set the bit again once it has been cleared.
- R5: Writing to address 1 sets every status bit whose write-data bit is 1. Write-data bits that are 0 leave the status unchanged.
- R6: Writing to address 2 clears every status bit whose write-data bit is 1. Write-data bits that are 0 leave the status unchanged.
- R7: When a hardware event and a clear reach the same status bit in the same cycle, the bit ends up set.
- R8: Reading address 1 returns the status in bits 4:0 and the current core_irq_lvl in bit 31, with bits 30:5 at 0.
- R9: irq_out is 1 exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_irq_lvl | input | 1 | Live interrupt level from the core |
| hpd_rise_evt | input | 1 | Hot-plug rise event pulse |
| hpd_fall_evt | input | 1 | Hot-plug fall event pulse |
| nonce_evt | input | 1 | Nonce refresh event pulse |
| rnd_err_evt | input | 1 | Random-number error event pulse |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
The pulse sources are first fired one at a time with the mask fully closed and then with it open. This separates status latching from gating of the request line. The core level is held high across a clear, then dropped and raised again, which tells edge detection apart from level detection. Writes to the status and clear registers use mixed 1/0 patterns to show that 0 bits have no effect. A clear that arrives in the same cycle as an event shows which of the two wins. A cycle-by-cycle model compares the read data and irq_out on every clock.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;
    localparam int NSRC   = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam int SRC_CORE  = 0;
    localparam int SRC_HPDR  = 1;
    localparam int SRC_HPDF  = 2;
    localparam int SRC_NONCE = 3;
    localparam int SRC_RND   = 4;

    localparam logic [ADDR_W-1:0] ADR_MASK = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 4'd2;

    localparam int LIVE_BIT = DATA_W - 1;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_sticky_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    lvl_state_e state_q;
    lvl_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise_o = lvl_i;
            LVL_HIGH: rise_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set_i,
    input  logic [N-1:0] sw_set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                        bit_q <= 1'b0;
            else if (hw_set_i[k] || sw_set_i[k]) bit_q <= 1'b1;
            else if (clr_i[k])                 bit_q <= 1'b0;
        end
        assign status_o[k] = bit_q;
    end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_sticky_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [NSRC-1:0]   status_i,
    input  logic              live_lvl_i,
    output logic [NSRC-1:0]   mask_o,
    output logic [NSRC-1:0]   sw_set_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [DATA_W-1:0] reg_rdata
);
    logic [NSRC-1:0] mask_q;
    logic            unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:NSRC];

    always_ff @(posedge clk) begin
        if (!rst_n)                               mask_q <= '0;
        else if (reg_we && reg_addr == ADR_MASK)  mask_q <= reg_wdata[NSRC-1:0];
    end

    always_comb begin
        sw_set_o = (reg_we && reg_addr == ADR_STAT) ? reg_wdata[NSRC-1:0] : '0;
        clr_o    = (reg_we && reg_addr == ADR_CLR)  ? reg_wdata[NSRC-1:0] : '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_MASK) begin
            reg_rdata[NSRC-1:0] = mask_q;
        end else if (reg_addr == ADR_STAT) begin
            reg_rdata[NSRC-1:0] = status_i;
            reg_rdata[LIVE_BIT] = live_lvl_i;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
    import irq_sticky_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_irq_lvl,
    input  logic              hpd_rise_evt,
    input  logic              hpd_fall_evt,
    input  logic              nonce_evt,
    input  logic              rnd_err_evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    logic            core_rise;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] sw_set;
    logic [NSRC-1:0] clr_bits;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;

    irq_edge_fsm u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (core_irq_lvl),
        .rise_o (core_rise)
    );

    always_comb begin
        hw_set            = '0;
        hw_set[SRC_CORE]  = core_rise;
        hw_set[SRC_HPDR]  = hpd_rise_evt;
        hw_set[SRC_HPDF]  = hpd_fall_evt;
        hw_set[SRC_NONCE] = nonce_evt;
        hw_set[SRC_RND]   = rnd_err_evt;
    end

    irq_sticky_bank #(.N(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set_i (hw_set),
        .sw_set_i (sw_set),
        .clr_i    (clr_bits),
        .status_o (status_q)
    );

    irq_reg_port u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .status_i   (status_q),
        .live_lvl_i (core_irq_lvl),
        .mask_o     (mask_q),
        .sw_set_o   (sw_set),
        .clr_o      (clr_bits),
        .reg_rdata  (reg_rdata)
    );

    assign irq_out = |(status_q & mask_q);
endmodule

// File: rtl/irq_sticky_ctrl_chk.sv
module irq_sticky_ctrl_chk
    import irq_sticky_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              core_irq_lvl,
    input logic              hpd_rise_evt,
    input logic              hpd_fall_evt,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out,
    input logic [NSRC-1:0]   status_q,
    input logic [NSRC-1:0]   mask_q
);
    p_mask_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_MASK) |=> (mask_q == $past(reg_wdata[NSRC-1:0])));

    p_hpd_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hpd_fall_evt |=> status_q[SRC_HPDF]);

    p_core_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq_lvl && !$past(core_irq_lvl)) |=> status_q[SRC_CORE]);

    p_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_STAT && reg_wdata[SRC_NONCE]) |=> status_q[SRC_NONCE]);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_CLR && reg_wdata[SRC_HPDF] && !hpd_fall_evt)
        |=> !status_q[SRC_HPDF]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADR_CLR && reg_wdata[SRC_HPDR] && hpd_rise_evt)
        |=> status_q[SRC_HPDR]);

    p_live_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_STAT) |-> (reg_rdata[LIVE_BIT] == core_irq_lvl));

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) == '0) |-> !irq_out);
endmodule

bind irq_sticky_ctrl irq_sticky_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_irq_lvl (core_irq_lvl),
    .hpd_rise_evt (hpd_rise_evt),
    .hpd_fall_evt (hpd_fall_evt),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_out      (irq_out),
    .status_q     (status_q),
    .mask_q       (mask_q)
);

// File: tb/irq_sticky_ctrl_tb.sv
`timescale 1ns/1ps
module irq_sticky_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lvl = 1'b0;
    logic [3:0]  ev = 4'd0;
    logic [3:0]  addr = 4'd0;
    logic        we = 1'b0;
    logic [31:0] wd = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // behavioural reference state
    logic [4:0] m_mask, m_stat;
    logic       m_prev;

    always #4 clk = ~clk;

    irq_sticky_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_irq_lvl (lvl),
        .hpd_rise_evt (ev[0]),
        .hpd_fall_evt (ev[1]),
        .nonce_evt    (ev[2]),
        .rnd_err_evt  (ev[3]),
        .reg_addr     (addr),
        .reg_we       (we),
        .reg_wdata    (wd),
        .reg_rdata    (rdata),
        .irq_out      (irq)
    );

    always @(posedge clk) begin
        logic [4:0] hw, sw, cl;
        if (!rst_n) begin
            m_mask <= 5'd0; m_stat <= 5'd0; m_prev <= 1'b0;
        end else begin
            hw = {ev[3], ev[2], ev[1], ev[0], lvl & ~m_prev};
            sw = (we && addr == 4'd1) ? wd[4:0] : 5'd0;
            cl = (we && addr == 4'd2) ? wd[4:0] : 5'd0;
            m_stat <= (m_stat & ~cl) | hw | sw;
            if (we && addr == 4'd0) m_mask <= wd[4:0];
            m_prev <= lvl;
        end
    end

    function automatic logic [31:0] model_rd();
        if (addr == 4'd0) return {27'd0, m_mask};
        if (addr == 4'd1) return {lvl, 26'd0, m_stat};
        return 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle, then compare against the model away from the edge
    task automatic drv(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic l, input logic [3:0] e);
        @(negedge clk);
        we = w; addr = a; wd = d; lvl = l; ev = e;
        #2;
        chk((a == 4'd1) ? "R8 rdata" : "R2 rdata", rdata, model_rd());
        chk("R9 irq_out", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    endtask

    task automatic rd_stat(input string req, input logic l, input logic [4:0] exp);
        drv(1'b0, 4'd1, 32'd0, l, 4'd0);
        chk(req, {27'd0, rdata[4:0]}, {27'd0, exp});
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        addr = 4'd0; #1;
        chk("R1 mask", rdata, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        addr = 4'd1; #1;
        chk("R1 status", rdata, 32'd0);

        // R3 events with mask closed: status latches, irq stays low
        drv(1'b0, 4'd1, 32'd0, 1'b0, 4'b0001);
        rd_stat("R3 hpd rise", 1'b0, 5'b00010);
        chk("R9 masked off", {31'd0, irq}, 32'd0);
        drv(1'b0, 4'd1, 32'd0, 1'b0, 4'b1100);
        drv(1'b0, 4'd1, 32'd0, 1'b0, 4'b0010);
        rd_stat("R3 all pulses sticky", 1'b0, 5'b11110);

        // R2 mask write/read, R9 open mask
        drv(1'b1, 4'd0, 32'hFFFF_FFF4, 1'b0, 4'd0);
        drv(1'b0, 4'd0, 32'd0, 1'b0, 4'd0);
        chk("R2 mask readback", rdata, 32'h0000_0014);
        chk("R9 irq on", {31'd0, irq}, 32'd1);
        drv(1'b0, 4'd5, 32'd0, 1'b0, 4'd0);
        chk("R2 unmapped read", rdata, 32'd0);

        // R6 clear with mixed pattern
        drv(1'b1, 4'd2, 32'h0000_0006, 1'b0, 4'd0);
        rd_stat("R6 partial clear", 1'b0, 5'b11000);
        drv(1'b1, 4'd2, 32'h0000_0018, 1'b0, 4'd0);
        rd_stat("R6 full clear", 1'b0, 5'b00000);
        chk("R9 irq off", {31'd0, irq}, 32'd0);

        // R4 core edge, hold high across clear, re-rise; R8 live bit
        drv(1'b0, 4'd1, 32'd0, 1'b1, 4'd0);
        rd_stat("R4 core rise", 1'b1, 5'b00001);
        chk("R8 live high", {31'd0, rdata[31]}, 32'd1);
        drv(1'b1, 4'd2, 32'h1, 1'b1, 4'd0);
        drv(1'b0, 4'd1, 32'd0, 1'b1, 4'd0);
        rd_stat("R4 held level no reset", 1'b1, 5'b00000);
        drv(1'b0, 4'd1, 32'd0, 1'b0, 4'd0);
        chk("R8 live low", {31'd0, rdata[31]}, 32'd0);
        drv(1'b0, 4'd1, 32'd0, 1'b1, 4'd0);
        rd_stat("R4 re-rise", 1'b1, 5'b00001);

        // R5 software set, zero bits ignored
        drv(1'b1, 4'd1, 32'h0000_0008, 1'b1, 4'd0);
        rd_stat("R5 sw set", 1'b1, 5'b01001);
        drv(1'b1, 4'd1, 32'h0000_0000, 1'b1, 4'd0);
        rd_stat("R5 zero write", 1'b1, 5'b01001);
        drv(1'b1, 4'd2, 32'h0000_0000, 1'b1, 4'd0);
        rd_stat("R6 zero clear", 1'b1, 5'b01001);

        // R7 event and clear on same bit
        drv(1'b1, 4'd2, 32'h0000_000B, 1'b1, 4'b0001);
        rd_stat("R7 set wins", 1'b1, 5'b00010);

        // R9 mask gating of single bit
        drv(1'b1, 4'd0, 32'h0000_0002, 1'b1, 4'd0);
        drv(1'b0, 4'd1, 32'd0, 1'b1, 4'd0);
        chk("R9 single enabled", {31'd0, irq}, 32'd1);
        drv(1'b1, 4'd0, 32'h0000_001D, 1'b1, 4'd0);
        drv(1'b0, 4'd1, 32'd0, 1'b1, 4'd0);
        chk("R9 other bits only", {31'd0, irq}, 32'd0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule